// File: doc/BRIEF.md
# Cross-Path Operand Router with Write-Hazard Stall

This block serves a two-sided processor datapath. Each side owns a 32-entry, 32-bit register file and four execution units. Any unit may ask for one source operand from the register file on the opposite side. Those requests travel over two shared cross buses. The bus feeding side A reads file B, and the bus feeding side B reads file A. Each bus carries a single register value per cycle, and at most two units of its side may consume that value.

An execute packet is presented with a valid/ready handshake. The block checks the packet's cross requests against the bus limits and raises an error for a packet that breaks them. A packet in error is dropped, and its own ready is still given. For a legal packet, the block compares each bus's register index against the writes committed in the previous cycle. If one of them matches, the block stalls the packet for one cycle by holding ready low. It then reads the register again, so the consumers see the freshly written value. Units on the other side of the stream have nothing to insert: the stall comes from hardware.

Both files are written through one port each. A write is presented with its enable, index and data, and it is stored at the next clock edge. A downstream stage may not apply back-pressure to the routed operands. They are valid only in the cycle in which the packet is accepted, which is when `pkt_valid` and `pkt_ready` are both high.

Top module: `xp_cross_read`

## Requirements
- R1: After reset, every register of both files reads zero and the write history is empty, so the first packet accepted after reset does not stall and `pkt_ready` is 1.
- R2: Units 0–3 form side A and units 4–7 form side B. A request with `req_vld[u]=1` and `req_xsel[u]=1` on a side-A unit returns register `req_idx[u*5+:5]` of file B. The same request on a side-B unit returns that register of file A. The value is driven on `xop_data[u*32+:32]`, with `xop_valid[u]=1`, in the cycle the packet is accepted.
- R3: Two units of one side that cross-request the same index both receive that register's value in the same cycle.
- R4: Three or more cross requesters on one side make `pkt_err` high while `pkt_valid` is high.
- R5: Two cross requesters on one side with different indices make `pkt_err` high.
- R6: While `pkt_err` is high, every `xop_valid` bit is 0, `stall` is 0 and `pkt_ready` is 1, so the packet is dropped.
- R7: If a legal packet's bus index on a side matches a register of the opposite file that was written in the previous cycle, `stall` is 1, `pkt_ready` is 0 and no operand is valid. With no new write during the stall, the next cycle accepts the packet without a stall and returns the newly written value.
- R8: A write to the file a side's bus does not read causes no stall. A write committed two or more cycles earlier causes no stall.
- R9: A write during a stall cycle to a register the held packet cross-reads causes one further stall cycle. After that, the value from the latest write is returned.
- R10: A request with `req_vld=0` or `req_xsel=0` produces no operand and does not count toward the bus limits.
- R11: With `pkt_valid` low, `stall`, `pkt_err` and all `xop_valid` bits are 0.
- R12: A write with `wb_en[f]=1` (f=0 is file A, f=1 is file B) stores `wb_data[f*32+:32]` at `wb_idx[f*5+:5]` at the clock edge. Cross reads see that value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Execute packet present |
| pkt_ready | output | 1 | Packet accepted or dropped this cycle; low during a stall |
| req_vld | input | 8 | Per-unit source request valid |
| req_xsel | input | 8 | Per-unit select of the opposite file |
| req_idx | input | 40 | Per-unit 5-bit register index, unit u at bits u*5 |
| wb_en | input | 2 | Write enable per file (bit 0 file A, bit 1 file B) |
| wb_idx | input | 10 | Write index per file |
| wb_data | input | 64 | Write data per file |
| xop_valid | output | 8 | Per-unit routed operand valid |
| xop_data | output | 256 | Per-unit routed operand, unit u at bits u*32 |
| stall | output | 1 | One-cycle hazard stall |
| pkt_err | output | 1 | Packet breaks the cross-bus limits |

## Verification
The routing is tried with single cross requests on each side, with two units sharing one bus index, and with requests whose select or valid bit is clear. Together these separate correct file and bus selection from unit masking. Illegal packets use three requesters, and separately two distinct indices on one bus, so the two error causes are told apart. The stall logic is tried with a write one cycle before the read, with a write to the file the bus does not read, with a write two cycles old, with a repeated write during the stall, and with an idle packet slot after a write. These cases distinguish the correct history match from a stall that fires too broadly or clears too early.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int NUM_SIDES = 2;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  function automatic int far_side(input int s);
    return (NUM_SIDES - 1) - s;
  endfunction
endpackage

// File: rtl/xp_regfile.sv
module xp_regfile #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/xp_bus_check.sv
module xp_bus_check #(
  parameter int N         = 4,
  parameter int IDX_W     = 5,
  parameter int MAX_SHARE = 2
) (
  input  logic [N-1:0]       act,
  input  logic [N*IDX_W-1:0] idx,
  output logic               used,
  output logic [IDX_W-1:0]   sel_idx,
  output logic               err
);
  localparam int CNT_W = $clog2(N + 1);

  logic [CNT_W-1:0] cnt;
  logic             mism;

  always_comb begin
    cnt     = '0;
    mism    = 1'b0;
    used    = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i]) begin
        cnt = cnt + 1'b1;
        if (!used) begin
          used    = 1'b1;
          sel_idx = idx[i*IDX_W +: IDX_W];
        end else if (idx[i*IDX_W +: IDX_W] != sel_idx) begin
          mism = 1'b1;
        end
      end
    end
    err = mism || (int'(cnt) > MAX_SHARE);
  end
endmodule

// File: rtl/xp_hazard.sv
module xp_hazard #(
  parameter int NFILES = 2,
  parameter int IDX_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NFILES-1:0]       wr_en,
  input  logic [NFILES*IDX_W-1:0] wr_idx,
  input  logic [NFILES-1:0]       rd_used,
  input  logic [NFILES*IDX_W-1:0] rd_idx,
  output logic [NFILES-1:0]       hit
);
  // One-cycle write history per file, refreshed every cycle, stalls included.
  logic [NFILES-1:0]  hist_en;
  logic [IDX_W-1:0]   hist_idx [NFILES];

  for (genvar f = 0; f < NFILES; f++) begin : g_file
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist_en[f]  <= 1'b0;
        hist_idx[f] <= '0;
      end else begin
        hist_en[f]  <= wr_en[f];
        hist_idx[f] <= wr_idx[f*IDX_W +: IDX_W];
      end
    end

    assign hit[f] = rd_used[f] && hist_en[f] &&
                    (hist_idx[f] == rd_idx[f*IDX_W +: IDX_W]);
  end
endmodule

// File: rtl/xp_cross_read.sv
module xp_cross_read
  import xp_pkg::*;
#(
  parameter int NUM_REGS       = 32,
  parameter int DATA_W         = 32,
  parameter int UNITS_PER_SIDE = 4,
  parameter int MAX_SHARE      = 2,
  localparam int IDX_W         = $clog2(NUM_REGS),
  localparam int NUM_UNITS     = NUM_SIDES * UNITS_PER_SIDE
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pkt_valid,
  output logic                        pkt_ready,
  input  logic [NUM_UNITS-1:0]        req_vld,
  input  logic [NUM_UNITS-1:0]        req_xsel,
  input  logic [NUM_UNITS*IDX_W-1:0]  req_idx,
  input  logic [NUM_SIDES-1:0]        wb_en,
  input  logic [NUM_SIDES*IDX_W-1:0]  wb_idx,
  input  logic [NUM_SIDES*DATA_W-1:0] wb_data,
  output logic [NUM_UNITS-1:0]        xop_valid,
  output logic [NUM_UNITS*DATA_W-1:0] xop_data,
  output logic                        stall,
  output logic                        pkt_err
);
  // Bus s feeds side s and reads the file of the far side.
  logic [NUM_SIDES-1:0] bus_used;
  logic [IDX_W-1:0]     bus_idx  [NUM_SIDES];
  logic [DATA_W-1:0]    bus_data [NUM_SIDES];
  logic [DATA_W-1:0]    file_rd  [NUM_SIDES];
  logic [NUM_SIDES-1:0] side_err;

  logic [NUM_SIDES-1:0]       file_rd_used;
  logic [NUM_SIDES*IDX_W-1:0] file_rd_idx;
  logic [NUM_SIDES-1:0]       hz_hit;
  logic                       fire;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int FAR = far_side(s);
    logic [UNITS_PER_SIDE-1:0] act;

    assign act = req_vld[s*UNITS_PER_SIDE +: UNITS_PER_SIDE] &
                 req_xsel[s*UNITS_PER_SIDE +: UNITS_PER_SIDE];

    xp_bus_check #(
      .N        (UNITS_PER_SIDE),
      .IDX_W    (IDX_W),
      .MAX_SHARE(MAX_SHARE)
    ) u_bus (
      .act    (act),
      .idx    (req_idx[s*UNITS_PER_SIDE*IDX_W +: UNITS_PER_SIDE*IDX_W]),
      .used   (bus_used[s]),
      .sel_idx(bus_idx[s]),
      .err    (side_err[s])
    );

    // File s is read by the bus serving the far side.
    xp_regfile #(
      .DEPTH (NUM_REGS),
      .DATA_W(DATA_W)
    ) u_file (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wb_en[s]),
      .widx (wb_idx[s*IDX_W +: IDX_W]),
      .wdata(wb_data[s*DATA_W +: DATA_W]),
      .ridx (bus_idx[FAR]),
      .rdata(file_rd[s])
    );

    assign bus_data[s]                       = file_rd[FAR];
    assign file_rd_used[s]                   = bus_used[FAR];
    assign file_rd_idx[s*IDX_W +: IDX_W]     = bus_idx[FAR];
  end

  xp_hazard #(
    .NFILES(NUM_SIDES),
    .IDX_W (IDX_W)
  ) u_hazard (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wb_en),
    .wr_idx (wb_idx),
    .rd_used(file_rd_used),
    .rd_idx (file_rd_idx),
    .hit    (hz_hit)
  );

  assign pkt_err   = pkt_valid && (|side_err);
  assign stall     = pkt_valid && !(|side_err) && (|hz_hit);
  assign pkt_ready = !stall;
  assign fire      = pkt_valid && !(|side_err) && !(|hz_hit);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int SIDE = u / UNITS_PER_SIDE;
    assign xop_valid[u] = fire && req_vld[u] && req_xsel[u];
    assign xop_data[u*DATA_W +: DATA_W] = xop_valid[u] ? bus_data[SIDE] : '0;
  end
endmodule

// File: rtl/xp_cross_read_chk.sv
module xp_cross_read_chk #(
  parameter int NUM_UNITS      = 8,
  parameter int UNITS_PER_SIDE = 4,
  parameter int DATA_W         = 32,
  parameter int NUM_SIDES      = 2,
  parameter int MAX_SHARE      = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        pkt_valid,
  input logic                        pkt_ready,
  input logic [NUM_UNITS-1:0]        req_vld,
  input logic [NUM_UNITS-1:0]        req_xsel,
  input logic [NUM_SIDES-1:0]        wb_en,
  input logic [NUM_UNITS-1:0]        xop_valid,
  input logic [NUM_UNITS*DATA_W-1:0] xop_data,
  input logic                        stall,
  input logic                        pkt_err
);
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |-> (xop_valid == '0 && !stall && pkt_ready)); // R6

  AST_OPS_ONLY_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (xop_valid & ~(req_vld & req_xsel)) == '0); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (xop_valid == '0 && !stall && !pkt_err)); // R11

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && wb_en == '0) |=> !stall); // R7

  AST_OLD_WRITE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wb_en) == '0) |-> !stall); // R8

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    AST_TOO_MANY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && $countones(req_vld[s*UNITS_PER_SIDE +: UNITS_PER_SIDE] &
        req_xsel[s*UNITS_PER_SIDE +: UNITS_PER_SIDE]) > MAX_SHARE) |-> pkt_err); // R4

    for (genvar a = 0; a < UNITS_PER_SIDE; a++) begin : g_a
      for (genvar b = a + 1; b < UNITS_PER_SIDE; b++) begin : g_b
        localparam int UA = s*UNITS_PER_SIDE + a;
        localparam int UB = s*UNITS_PER_SIDE + b;
        AST_SHARED_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
          (xop_valid[UA] && xop_valid[UB]) |->
          (xop_data[UA*DATA_W +: DATA_W] == xop_data[UB*DATA_W +: DATA_W])); // R3
      end
    end
  end
endmodule

bind xp_cross_read xp_cross_read_chk #(
  .NUM_UNITS     (NUM_UNITS),
  .UNITS_PER_SIDE(UNITS_PER_SIDE),
  .DATA_W        (DATA_W),
  .NUM_SIDES     (xp_pkg::NUM_SIDES),
  .MAX_SHARE     (MAX_SHARE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready),
  .req_vld  (req_vld),
  .req_xsel (req_xsel),
  .wb_en    (wb_en),
  .xop_valid(xop_valid),
  .xop_data (xop_data),
  .stall    (stall),
  .pkt_err  (pkt_err)
);

// File: tb/xp_cross_read_tb.sv
module xp_cross_read_tb;
  localparam int NU = 8;
  localparam int IW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pkt_valid = 1'b0;
  logic          pkt_ready;
  logic [NU-1:0] req_vld = '0;
  logic [NU-1:0] req_xsel = '0;
  logic [NU*IW-1:0] req_idx = '0;
  logic [1:0]    wb_en = '0;
  logic [2*IW-1:0] wb_idx = '0;
  logic [2*DW-1:0] wb_data = '0;
  logic [NU-1:0] xop_valid;
  logic [NU*DW-1:0] xop_data;
  logic          stall;
  logic          pkt_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  xp_cross_read u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .req_vld(req_vld), .req_xsel(req_xsel), .req_idx(req_idx),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .xop_valid(xop_valid), .xop_data(xop_data), .stall(stall), .pkt_err(pkt_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_pkt();
    pkt_valid = 1'b0; req_vld = '0; req_xsel = '0; req_idx = '0;
  endtask

  task automatic xreq(input int u, input int idx);
    pkt_valid = 1'b1;
    req_vld[u] = 1'b1; req_xsel[u] = 1'b1;
    req_idx[u*IW +: IW] = IW'(idx);
  endtask

  // Drive a write for one cycle, starting at the current negedge.
  task automatic wr_set(input int f, input int idx, input logic [DW-1:0] d);
    wb_en[f] = 1'b1; wb_idx[f*IW +: IW] = IW'(idx); wb_data[f*DW +: DW] = d;
  endtask

  task automatic next();
    @(negedge clk);
    wb_en = '0;
  endtask

  function automatic logic [DW-1:0] op(input int u);
    return xop_data[u*DW +: DW];
  endfunction

  task automatic t_reset();
    next(); clear_pkt();
    xreq(0, 5); xreq(4, 5);
    #2;
    check("R1 ready", 32'(pkt_ready), 1);
    check("R1 stall", 32'(stall), 0);
    check("R1 valid", 32'(xop_valid), 32'h11);
    check("R1 zeroA", op(0), 0);
    check("R1 zeroB", op(4), 0);
  endtask

  task automatic t_basic();
    next(); clear_pkt();
    wr_set(1, 5, 32'hB000_0005); wr_set(0, 7, 32'hA000_0007);
    next(); next();
    xreq(1, 5); xreq(6, 7);
    req_vld[2] = 1'b1; req_idx[2*IW +: IW] = 5'd9;   // same-side read, R10
    req_xsel[7] = 1'b1; req_idx[7*IW +: IW] = 5'd3;  // select without valid, R10
    #2;
    check("R2 sideA from B", op(1), 32'hB000_0005);
    check("R2 sideB from A", op(6), 32'hA000_0007);
    check("R12 written value seen", 32'(xop_valid), 32'h42);
    check("R10 masked units", op(2) | op(7), 0);
    check("R10 no error", 32'(pkt_err), 0);
  endtask

  task automatic t_share();
    next(); clear_pkt();
    xreq(0, 5); xreq(3, 5);
    #2;
    check("R3 unit0", op(0), 32'hB000_0005);
    check("R3 unit3", op(3), 32'hB000_0005);
    check("R3 err", 32'(pkt_err), 0);
  endtask

  task automatic t_three();
    next(); clear_pkt();
    xreq(0, 5); xreq(1, 5); xreq(2, 5);
    #2;
    check("R4 err", 32'(pkt_err), 1);
    check("R6 no ops", 32'(xop_valid), 0);
    check("R6 no stall", 32'(stall), 0);
    check("R6 ready", 32'(pkt_ready), 1);
  endtask

  task automatic t_distinct();
    next(); clear_pkt();
    xreq(4, 7); xreq(5, 8);
    #2;
    check("R5 err", 32'(pkt_err), 1);
    check("R6 no ops", 32'(xop_valid), 0);
  endtask

  task automatic t_hazard();
    next(); clear_pkt();
    wr_set(1, 9, 32'h1234_5678);
    next();
    xreq(0, 9);
    #2;
    check("R7 stall", 32'(stall), 1);
    check("R7 ready low", 32'(pkt_ready), 0);
    check("R7 no ops", 32'(xop_valid), 0);
    next();
    #2;
    check("R7 released", 32'(stall), 0);
    check("R7 new value", op(0), 32'h1234_5678);
  endtask

  task automatic t_restall();
    next(); clear_pkt();
    wr_set(1, 10, 32'h0000_0001);
    next();
    xreq(5, 12);                                // side B reads A12
    xreq(2, 10);
    wr_set(1, 10, 32'h0000_0002);
    #2;
    check("R9 first stall", 32'(stall), 1);
    next();
    #2;
    check("R9 second stall", 32'(stall), 1);
    next();
    #2;
    check("R9 released", 32'(stall), 0);
    check("R9 latest value", op(2), 32'h0000_0002);
    check("R9 other side", op(5), 0);
  endtask

  task automatic t_no_false_stall();
    next(); clear_pkt();
    wr_set(0, 5, 32'hAAAA_0005);                // file A; side A bus reads B
    next();
    xreq(0, 5);
    #2;
    check("R8 same-side write", 32'(stall), 0);
    check("R8 same-side value", op(0), 32'hB000_0005);
    next(); clear_pkt();
    wr_set(1, 5, 32'hB111_0005);
    next(); next();
    xreq(1, 5);
    #2;
    check("R8 two-cycle-old write", 32'(stall), 0);
    check("R8 two-cycle value", op(1), 32'hB111_0005);
  endtask

  task automatic t_idle();
    next(); clear_pkt();
    wr_set(0, 7, 32'hA222_0007);
    next();
    req_vld[4] = 1'b1; req_xsel[4] = 1'b1; req_idx[4*IW +: IW] = 5'd7;
    #2;
    check("R11 no stall idle", 32'(stall), 0);
    check("R11 no ops idle", 32'(xop_valid), 0);
    check("R11 no err idle", 32'(pkt_err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_share();
    t_three();
    t_distinct();
    t_hazard();
    t_restall();
    t_no_false_stall();
    t_idle();
    next(); clear_pkt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule